// File: doc/BRIEF.md
# Data Memory Address Generator

This unit turns an access request into a 16-bit data memory address. A request names an addressing mode, a 7-bit select field and a post-modify command. The unit supports five modes:

- paged direct, where a 9-bit page register sits above the 7-bit offset;
- zero-page register access;
- indirect through one of eight 16-bit pointer registers;
- one of two fixed address registers;
- a circular walk, where a pointer register bound to one of two buffer windows wraps at the window edges.

The unit holds the page register, the pointer file, the two fixed registers and, for each of the two windows, a start bound, an end bound and a pointer binding. All of these are written through a single configuration write port.

Requests arrive on a valid/ready handshake. The address leaves on a valid/ready handshake through one output register. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While a presented address waits with `out_ready` low, the address and `out_valid` hold and `req_ready` stays low. A request that is not accepted has no effect on any register. Configuration writes are never back-pressured.

Top module: `dmem_agen`

## Requirements
- R1: Mode code 0 (paged direct) produces the address page*128 + req_sel.
- R2: Mode code 1 (zero page) produces the address req_sel, with bits 15..7 zero whatever the page register holds. Mode codes 5 to 7 behave as mode 0.
- R3: Mode code 2 (indirect) produces the value of pointer register req_sel[2:0].
- R4: In mode 2 the post-modify code acts on the used pointer after the address is taken: code 1 adds one, code 2 subtracts one, and codes 0 and 3 leave it unchanged. The arithmetic wraps modulo 65536.
- R5: Mode code 3 produces the value of fixed register req_sel[0]. Either fixed register can be rewritten at any time, and the next request returns the new value.
- R6: Mode code 4 (circular) uses window req_sel[0] and produces the value of the pointer bound to that window. With post code 1, a pointer equal to the window end is reloaded with the window start; otherwise it is incremented.
- R7: With post code 2 in mode 4, a pointer equal to the window start is reloaded with the window end; otherwise it is decremented. The two windows keep separate bounds and bindings, so requests to them can be interleaved freely.
- R8: cfg_we writes cfg_data to the target named by cfg_sel. The codes are: 0..7 pointer registers; 8 page (low 9 bits); 9 and 10 fixed registers 0 and 1; 11, 12, 13 window 0 start, end and binding (low 3 bits); 14, 15, 16 the same for window 1.
- R9: An address computed in a cycle uses register values from before that cycle's writes. When a configuration write and a post-modify hit the same pointer in one cycle, the configuration write wins.
- R10: Back-pressure. While out_valid is high and out_ready is low, out_addr and out_valid hold and req_ready is low. A request offered then is not accepted and modifies nothing.
- R11: An accepted request appears on out_valid/out_addr one clock later. With no accepted request and out_ready high, out_valid is low after the next clock.
- R12: After reset every register reads zero, out_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_mode | input | 3 | Addressing mode code |
| req_sel | input | 7 | Offset, pointer index, fixed register or window select |
| req_post | input | 2 | Post-modify code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Configuration target code |
| cfg_data | input | 16 | Configuration write value |
| out_valid | output | 1 | Address valid |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | 16 | Generated data memory address |

## Verification
Two functions can meet in one cycle: a configuration write and an accepted request that reads or post-modifies the same register. The bench provokes this by driving cfg_we and req_valid in the same cycle. Cases covered are a pointer rewrite against an indirect post-increment of that pointer, and a page reload against a paged direct request. The emitted address must carry the old value, and a later no-modify read must return the written value rather than the incremented one. Back-pressure is also made to coincide with a pending post-modify request, and a later read-back shows that the pointer moved only once.

// File: rtl/dmem_agen_pkg.sv
`timescale 1ns/1ps
package dmem_agen_pkg;
  typedef enum logic [2:0] {
    AM_PAGED = 3'd0,
    AM_ZPAGE = 3'd1,
    AM_PTR   = 3'd2,
    AM_FIXED = 3'd3,
    AM_RING  = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    PM_KEEP = 2'd0,
    PM_INC  = 2'd1,
    PM_DEC  = 2'd2,
    PM_KEEP2 = 2'd3
  } pmod_e;
endpackage

// File: rtl/dmem_agen_ring.sv
`timescale 1ns/1ps
module dmem_agen_ring
  import dmem_agen_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [1:0]    post,
  output logic [AW-1:0] nxt
);
  always_comb begin
    case (pmod_e'(post))
      PM_INC:  nxt = (cur == hi) ? lo : cur + AW'(1);
      PM_DEC:  nxt = (cur == lo) ? hi : cur - AW'(1);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dmem_agen_regs.sv
`timescale 1ns/1ps
module dmem_agen_regs #(
  parameter int AW       = 16,
  parameter int PW       = 9,
  parameter int NUM_AR   = 8,
  parameter int NUM_DED  = 2,
  parameter int NUM_CIRC = 2,
  parameter int CSW      = 5,
  parameter int ARIW     = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [CSW-1:0]                 cfg_sel,
  input  logic [AW-1:0]                  cfg_data,
  input  logic                           mod_en,
  input  logic [ARIW-1:0]                mod_idx,
  input  logic [AW-1:0]                  mod_val,
  output logic [NUM_AR-1:0][AW-1:0]      ar_q,
  output logic [PW-1:0]                  page_q,
  output logic [NUM_DED-1:0][AW-1:0]     ded_q,
  output logic [NUM_CIRC-1:0][AW-1:0]    cstart_q,
  output logic [NUM_CIRC-1:0][AW-1:0]    cend_q,
  output logic [NUM_CIRC-1:0][ARIW-1:0]  cidx_q
);
  localparam int SEL_PAGE = NUM_AR;
  localparam int SEL_DED  = NUM_AR + 1;
  localparam int SEL_RING = NUM_AR + 1 + NUM_DED;

  // Pointer file: a configuration write takes priority over a post-modify.
  for (genvar i = 0; i < NUM_AR; i++) begin : g_ar
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ar_q[i] <= '0;
      else if (cfg_we && cfg_sel == CSW'(i))     ar_q[i] <= cfg_data;
      else if (mod_en && mod_idx == ARIW'(i))    ar_q[i] <= mod_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  page_q <= '0;
    else if (cfg_we && cfg_sel == CSW'(SEL_PAGE)) page_q <= cfg_data[PW-1:0];
  end

  for (genvar j = 0; j < NUM_DED; j++) begin : g_ded
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    ded_q[j] <= '0;
      else if (cfg_we && cfg_sel == CSW'(SEL_DED + j)) ded_q[j] <= cfg_data;
    end
  end

  for (genvar k = 0; k < NUM_CIRC; k++) begin : g_ring
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cstart_q[k] <= '0;
        cend_q[k]   <= '0;
        cidx_q[k]   <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == CSW'(SEL_RING + 3*k))     cstart_q[k] <= cfg_data;
        if (cfg_sel == CSW'(SEL_RING + 3*k + 1)) cend_q[k]   <= cfg_data;
        if (cfg_sel == CSW'(SEL_RING + 3*k + 2)) cidx_q[k]   <= cfg_data[ARIW-1:0];
      end
    end
  end
endmodule

// File: rtl/dmem_agen.sv
`timescale 1ns/1ps
module dmem_agen
  import dmem_agen_pkg::*;
#(
  parameter int PW       = 9,
  parameter int OW       = 7,
  parameter int NUM_AR   = 8,
  parameter int NUM_DED  = 2,
  parameter int NUM_CIRC = 2,
  localparam int AW      = PW + OW,
  localparam int CSW     = $clog2(NUM_AR + 1 + NUM_DED + 3*NUM_CIRC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [2:0]     req_mode,
  input  logic [OW-1:0]  req_sel,
  input  logic [1:0]     req_post,
  input  logic           cfg_we,
  input  logic [CSW-1:0] cfg_sel,
  input  logic [AW-1:0]  cfg_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [AW-1:0]  out_addr
);
  localparam int ARIW = $clog2(NUM_AR);
  localparam int DEDW = (NUM_DED  > 1) ? $clog2(NUM_DED)  : 1;
  localparam int CIW  = (NUM_CIRC > 1) ? $clog2(NUM_CIRC) : 1;

  logic [NUM_AR-1:0][AW-1:0]     ar_q;
  logic [PW-1:0]                 page_q;
  logic [NUM_DED-1:0][AW-1:0]    ded_q;
  logic [NUM_CIRC-1:0][AW-1:0]   cstart_q, cend_q, ring_nxt;
  logic [NUM_CIRC-1:0][ARIW-1:0] cidx_q;

  logic            accept, stepping;
  logic            mod_en;
  logic [ARIW-1:0] mod_idx;
  logic [AW-1:0]   mod_val, addr_c;
  logic [ARIW-1:0] ar_sel;
  logic [DEDW-1:0] ded_sel;
  logic [CIW-1:0]  ring_sel;

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;
  assign stepping  = (req_post == PM_INC) || (req_post == PM_DEC);
  assign ar_sel    = req_sel[ARIW-1:0];
  assign ded_sel   = req_sel[DEDW-1:0];
  assign ring_sel  = req_sel[CIW-1:0];

  dmem_agen_regs #(
    .AW(AW), .PW(PW), .NUM_AR(NUM_AR), .NUM_DED(NUM_DED),
    .NUM_CIRC(NUM_CIRC), .CSW(CSW), .ARIW(ARIW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .mod_en(mod_en), .mod_idx(mod_idx), .mod_val(mod_val),
    .ar_q(ar_q), .page_q(page_q), .ded_q(ded_q),
    .cstart_q(cstart_q), .cend_q(cend_q), .cidx_q(cidx_q)
  );

  // One wrap unit per window, fed by the pointer bound to that window.
  for (genvar k = 0; k < NUM_CIRC; k++) begin : g_wrap
    dmem_agen_ring #(.AW(AW)) u_ring (
      .cur(ar_q[cidx_q[k]]), .lo(cstart_q[k]), .hi(cend_q[k]),
      .post(req_post), .nxt(ring_nxt[k])
    );
  end

  always_comb begin
    addr_c  = {page_q, req_sel};
    mod_en  = 1'b0;
    mod_idx = ar_sel;
    mod_val = ar_q[ar_sel];
    case (amode_e'(req_mode))
      AM_ZPAGE: addr_c = {{PW{1'b0}}, req_sel};
      AM_PTR: begin
        addr_c  = ar_q[ar_sel];
        mod_en  = accept && stepping;
        mod_val = (req_post == PM_INC) ? ar_q[ar_sel] + AW'(1)
                                       : ar_q[ar_sel] - AW'(1);
      end
      AM_FIXED: addr_c = ded_q[ded_sel];
      AM_RING: begin
        addr_c  = ar_q[cidx_q[ring_sel]];
        mod_en  = accept && stepping;
        mod_idx = cidx_q[ring_sel];
        mod_val = ring_nxt[ring_sel];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_addr  <= addr_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dmem_agen_chk.sv
`timescale 1ns/1ps
module dmem_agen_chk #(
  parameter int AW = 16,
  parameter int OW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_mode,
  input logic [OW-1:0] req_sel,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R11
  issue_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R11
  drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && out_ready) |=> !out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !req_ready);

  // R2
  zpage_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_mode == 3'd1) |=> (out_addr[AW-1:OW] == '0));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_mode == 3'd0 || req_mode == 3'd1)) |=>
      (out_addr[OW-1:0] == $past(req_sel)));
endmodule

bind dmem_agen dmem_agen_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mode(req_mode), .req_sel(req_sel), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr)
);

// File: tb/tb_dmem_agen.sv
`timescale 1ns/1ps
module tb_dmem_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic [6:0]  req_sel = '0;
  logic [1:0]  req_post = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m_ar [8];

  always #5 clk = ~clk;

  dmem_agen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_sel(req_sel), .req_post(req_post),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [4:0] s, logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issue one request, then check the address one clock later.
  task automatic req(string tag, logic [2:0] m, logic [6:0] s, logic [1:0] p,
                     logic [15:0] exp);
    req_valid = 1'b1; req_mode = m; req_sel = s; req_post = p;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check(tag, {16'd0, out_addr}, {16'd0, exp});
  endtask

  function automatic logic [15:0] wrap(logic [15:0] c, logic [15:0] lo,
                                       logic [15:0] hi, logic [1:0] p);
    if (p == 2'd1) return (c == hi) ? lo : c + 16'd1;
    if (p == 2'd2) return (c == lo) ? hi : c - 16'd1;
    return c;
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 out_valid", {31'd0, out_valid}, 32'd0);
    check("R12 req_ready", {31'd0, req_ready}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      req("R12 pointer zero", 3'd2, 7'(i), 2'd0, 16'h0);
      m_ar[i] = 16'h0;
    end
    req("R12 fixed zero", 3'd3, 7'd1, 2'd0, 16'h0);
    req("R12 page zero", 3'd0, 7'd5, 2'd0, 16'd5);

    // R1 + R8 paged direct sweep
    foreach (c0[i]) ;
    for (int pg = 0; pg < 4; pg++) begin
      logic [8:0] pv;
      pv = (pg == 0) ? 9'h000 : (pg == 1) ? 9'h001 : (pg == 2) ? 9'h155 : 9'h1FF;
      cfg(5'd8, {7'h7F, pv});
      for (int o = 0; o < 128; o++)
        req("R1 paged", 3'd0, 7'(o), 2'd0, 16'(pv * 128 + o));
    end
    // R2 zero page with page = 0x1FF; reserved codes behave as paged
    for (int o = 0; o < 128; o++)
      req("R2 zero page", 3'd1, 7'(o), 2'd0, 16'(o));
    for (int m = 5; m < 8; m++)
      req("R2 reserved code", 3'(m), 7'h11, 2'd0, 16'(9'h1FF * 128 + 7'h11));

    // R3 + R8 pointer loads and reads; upper select bits ignored
    for (int i = 0; i < 8; i++) begin
      m_ar[i] = 16'(16'h1000 * i + 16'h0123 + i);
      cfg(5'(i), m_ar[i]);
    end
    for (int i = 0; i < 8; i++)
      req("R3 indirect", 3'd2, {4'b1010, 3'(i)}, 2'd0, m_ar[i]);

    // R4 post-modify codes incl. wrap
    cfg(5'd3, 16'hFFFE); m_ar[3] = 16'hFFFE;
    for (int k = 0; k < 4; k++) begin
      req("R4 inc", 3'd2, 7'd3, 2'd1, m_ar[3]);
      m_ar[3] = m_ar[3] + 16'd1;
    end
    for (int k = 0; k < 5; k++) begin
      req("R4 dec", 3'd2, 7'd3, 2'd2, m_ar[3]);
      m_ar[3] = m_ar[3] - 16'd1;
    end
    req("R4 code0 keep", 3'd2, 7'd3, 2'd0, m_ar[3]);
    req("R4 code3 keep", 3'd2, 7'd3, 2'd3, m_ar[3]);
    req("R4 after keep", 3'd2, 7'd3, 2'd0, m_ar[3]);

    // R5 fixed registers
    cfg(5'd9, 16'hA5A5); cfg(5'd10, 16'h5A5A);
    req("R5 fixed0", 3'd3, 7'd0, 2'd0, 16'hA5A5);
    req("R5 fixed1", 3'd3, 7'd1, 2'd0, 16'h5A5A);
    cfg(5'd10, 16'h0F0F);
    req("R5 fixed1 reload", 3'd3, 7'd1, 2'd0, 16'h0F0F);

    // R6 / R7 two windows interleaved
    cfg(5'd11, 16'h0200); cfg(5'd12, 16'h0203); cfg(5'd13, 16'd2);
    cfg(5'd14, 16'h0300); cfg(5'd15, 16'h0305); cfg(5'd16, 16'd5);
    cfg(5'd2, 16'h0200); cfg(5'd5, 16'h0303);
    c0 = 16'h0200; c1 = 16'h0303;
    for (int k = 0; k < 10; k++) begin
      req("R6 window0 inc", 3'd4, 7'd0, 2'd1, c0);
      c0 = wrap(c0, 16'h0200, 16'h0203, 2'd1);
      req("R7 window1 inc", 3'd4, 7'd1, 2'd1, c1);
      c1 = wrap(c1, 16'h0300, 16'h0305, 2'd1);
    end
    for (int k = 0; k < 6; k++) begin
      req("R7 window0 dec", 3'd4, 7'd0, 2'd2, c0);
      c0 = wrap(c0, 16'h0200, 16'h0203, 2'd2);
    end
    req("R6 bound pointer read", 3'd2, 7'd2, 2'd0, c0);
    req("R7 bound pointer read", 3'd2, 7'd5, 2'd0, c1);

    // R9 same-cycle write and post-modify on one pointer
    cfg_we = 1'b1; cfg_sel = 5'd6; cfg_data = 16'h7777;
    req("R9 old value issued", 3'd2, 7'd6, 2'd1, m_ar[6]);
    cfg_we = 1'b0;
    req("R9 write wins", 3'd2, 7'd6, 2'd0, 16'h7777);
    cfg_we = 1'b1; cfg_sel = 5'd8; cfg_data = 16'h0002;
    req("R9 old page issued", 3'd0, 7'd4, 2'd0, 16'(9'h1FF * 128 + 4));
    cfg_we = 1'b0;
    req("R9 new page", 3'd0, 7'd4, 2'd0, 16'(2 * 128 + 4));

    // R10 back-pressure with a pending post-modify request
    cfg(5'd1, 16'h4000);
    @(negedge clk);
    out_ready = 1'b0;
    req("R10 first accepted", 3'd2, 7'd1, 2'd1, 16'h4000);
    req_valid = 1'b1; req_mode = 3'd2; req_sel = 7'd1; req_post = 2'd1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R10 hold valid", {31'd0, out_valid}, 32'd1);
      check("R10 hold addr", {16'd0, out_addr}, 32'h4000);
      check("R10 ready low", {31'd0, req_ready}, 32'd0);
    end
    req_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    // R11 drained output clears
    check("R11 drain clears", {31'd0, out_valid}, 32'd0);
    req("R10 single step only", 3'd2, 7'd1, 2'd0, 16'h4001);
    @(negedge clk);
    check("R11 idle low", {31'd0, out_valid}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule